// File: doc/BRIEF.md
# Grouped Priority Request Selector

This block picks the next request to issue from a small pending-request buffer on one memory channel. Each buffer slot offers a valid flag, the hardware-context number of its requester, a flag saying the request hits the currently open row, and an arrival sequence number. A separate unit supplies a per-context vector that marks some contexts as penalised. The selector looks up each slot's context in that vector. It then chooses one slot by three ordered rules. First, requests from unpenalised contexts win. Second, row hits win. Third, older requests win.

The decision is built in one clock cycle. A comparison key is formed for every slot, a balanced reduction tree finds the largest key among the valid slots, and the result is registered. The registered result is a one-hot grant vector, the binary index of the chosen slot, and a flag that says a grant exists. The issuing logic reads these outputs on the cycle after it presents the buffer contents. The decision is recomputed every cycle, which gives a new grant well within the few command cycles the channel allows between issues.

Arrival numbers are a wrapping counter. The block is also given the sequence number that the next arrival would receive. It measures each slot's age as that number minus the slot's stamp, modulo the counter range. The ordering therefore stays correct across a wrap, provided no pending request is older than the counter range.

Top module: `rqarb_top`

## Requirements
- R1: A valid request whose context bit in `blacklist_i` is 0 is always chosen over any valid request whose context bit is 1 (bit k of `blacklist_i` belongs to context k; 1 means penalised).
- R2: Among valid requests with the same penalty bit, a request with `req_hit_i` = 1 is chosen over one with `req_hit_i` = 0.
- R3: Among valid requests equal on R1 and R2, the one with the largest age wins. Age is (`now_seq_i` − stamp) mod 2^SW, and the stamp of slot i is `req_seq_i[i*SW +: SW]`.
- R4: When several valid requests are equal on penalty bit, hit flag and age, the lowest slot index wins.
- R5: When no slot is valid, `grant_valid_o` is 0, `grant_o` is all zeros and `grant_idx_o` is 0.
- R6: `grant_o` has at most one bit set. When `grant_valid_o` is 1, that bit is bit `grant_idx_o`.
- R7: Outputs present, one cycle later, the decision for the inputs sampled at the previous rising clock edge. Between edges they do not change.
- R8: While `rst_ni` is low, all outputs are zero.
- R9: A slot whose valid bit is 0 is never granted, whatever its context, hit flag or stamp.
- R10: Ages are wraparound-safe. A stamp just below 2^SW is older than a stamp just above 0 when `now_seq_i` has wrapped past both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N | Valid flag per buffer slot |
| req_ctx_i | input | N*CW | Context number per slot; slot i at [i*CW +: CW] |
| req_hit_i | input | N | Open-row hit flag per slot |
| req_seq_i | input | N*SW | Arrival stamp per slot; slot i at [i*SW +: SW] |
| now_seq_i | input | SW | Sequence number the next arrival would receive |
| blacklist_i | input | NCTX | Penalty bit per context, 1 = penalised |
| grant_o | output | N | One-hot grant, registered |
| grant_idx_o | output | IW | Index of the granted slot, registered |
| grant_valid_o | output | 1 | A slot was granted, registered |

## Verification
A wrong internal state has a visible effect at the ports one cycle after the inputs that expose it. A key field built from the wrong context bit, from an inverted hit flag, or from an age taken without wrap correction makes `grant_idx_o` name a slot that loses by the rules. This shows up only for input patterns where the two competing slots differ in exactly that field. For that reason the sweeps hold two of the three fields fixed and vary the third. A tree node that breaks ties to the wrong side shows up only when keys are equal, so full-tie patterns over every subset of valid slots are run as well. An error in the output register or the one-hot decode shows as a grant vector that disagrees with the index, or as a grant that lags one more cycle.

// File: rtl/rqarb_pkg.sv
package rqarb_pkg;

  // Modular distance from a stamp to the current sequence number, w bits wide.
  function automatic logic [31:0] wrap_age(input logic [31:0] now,
                                           input logic [31:0] stamp,
                                           input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (now - stamp) & mask;
  endfunction

  // Width of an index able to address n items (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rqarb_keygen.sv
module rqarb_keygen #(
  parameter int unsigned N    = 8,
  parameter int unsigned NCTX = 4,
  parameter int unsigned SW   = 6,
  localparam int unsigned CW  = rqarb_pkg::idx_width(NCTX),
  localparam int unsigned KW  = SW + 2
) (
  input  logic [N-1:0]      valid_i,
  input  logic [N*CW-1:0]   ctx_i,
  input  logic [N-1:0]      hit_i,
  input  logic [N*SW-1:0]   seq_i,
  input  logic [SW-1:0]     now_i,
  input  logic [NCTX-1:0]   penal_i,
  output logic [N*KW-1:0]   key_o,
  output logic [N-1:0]      elig_o,
  output logic [N-1:0]      cand_o
);
  localparam int unsigned CTXS = 1 << CW;

  // Contexts beyond NCTX read as not penalised.
  logic [CTXS-1:0] penal_ext;
  assign penal_ext = CTXS'(penal_i);

  assign cand_o = valid_i;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [CW-1:0] ctx;
    logic [SW-1:0] age;
    logic          elig;
    assign ctx  = ctx_i[i*CW +: CW];
    assign elig = ~penal_ext[ctx];
    assign age  = SW'(rqarb_pkg::wrap_age(32'(now_i), 32'(seq_i[i*SW +: SW]), SW));
    assign elig_o[i] = elig;
    // Key order: group bit, then hit flag, then age (bigger = older).
    assign key_o[i*KW +: KW] = {elig, hit_i[i], age};
  end
endmodule

// File: rtl/rqarb_maxtree.sv
module rqarb_maxtree #(
  parameter int unsigned N  = 8,
  parameter int unsigned KW = 8,
  localparam int unsigned IW = rqarb_pkg::idx_width(N),
  localparam int unsigned P  = 1 << IW,
  localparam int unsigned NODES = 2 * P - 1
) (
  input  logic [N*KW-1:0] key_i,
  input  logic [N-1:0]    vld_i,
  output logic [KW-1:0]   win_key_o,
  output logic [IW-1:0]   win_idx_o,
  output logic            win_vld_o
);
  // Heap layout: node 0 is the root, leaves occupy P-1 .. 2P-2.
  logic [KW-1:0] nk [NODES];
  logic [IW-1:0] ni [NODES];
  logic          nv [NODES];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nk[P-1+j] = key_i[j*KW +: KW];
      assign nv[P-1+j] = vld_i[j];
    end else begin : g_pad
      assign nk[P-1+j] = '0;
      assign nv[P-1+j] = 1'b0;
    end
    assign ni[P-1+j] = IW'(j);
  end

  for (genvar i = 0; i < P - 1; i++) begin : g_node
    logic take_l;
    // The left subtree always holds lower indices, so equality keeps it (lowest index wins).
    assign take_l = nv[2*i+1] && (!nv[2*i+2] || (nk[2*i+1] >= nk[2*i+2]));
    assign nk[i] = take_l ? nk[2*i+1] : nk[2*i+2];
    assign ni[i] = take_l ? ni[2*i+1] : ni[2*i+2];
    assign nv[i] = nv[2*i+1] | nv[2*i+2];
  end

  assign win_key_o = nk[0];
  assign win_idx_o = ni[0];
  assign win_vld_o = nv[0];
endmodule

// File: rtl/rqarb_top.sv
module rqarb_top #(
  parameter int unsigned N    = 8,
  parameter int unsigned NCTX = 4,
  parameter int unsigned SW   = 6,
  localparam int unsigned CW  = rqarb_pkg::idx_width(NCTX),
  localparam int unsigned IW  = rqarb_pkg::idx_width(N),
  localparam int unsigned KW  = SW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_valid_i,
  input  logic [N*CW-1:0]   req_ctx_i,
  input  logic [N-1:0]      req_hit_i,
  input  logic [N*SW-1:0]   req_seq_i,
  input  logic [SW-1:0]     now_seq_i,
  input  logic [NCTX-1:0]   blacklist_i,
  output logic [N-1:0]      grant_o,
  output logic [IW-1:0]     grant_idx_o,
  output logic              grant_valid_o
);
  // Named internal events, visible to the assertions below.
  logic [N*KW-1:0] key_w;
  logic [N-1:0]    elig_w;
  logic [N-1:0]    cand_w;
  logic [KW-1:0]   win_key_w;
  logic [IW-1:0]   win_idx_w;
  logic            win_vld_w;
  logic [N-1:0]    win_onehot_w;
  logic [N-1:0]    hot_w;
  logic            armed_q;

  rqarb_keygen #(.N(N), .NCTX(NCTX), .SW(SW)) keygen_i (
    .valid_i (req_valid_i),
    .ctx_i   (req_ctx_i),
    .hit_i   (req_hit_i),
    .seq_i   (req_seq_i),
    .now_i   (now_seq_i),
    .penal_i (blacklist_i),
    .key_o   (key_w),
    .elig_o  (elig_w),
    .cand_o  (cand_w)
  );

  rqarb_maxtree #(.N(N), .KW(KW)) tree_i (
    .key_i     (key_w),
    .vld_i     (cand_w),
    .win_key_o (win_key_w),
    .win_idx_o (win_idx_w),
    .win_vld_o (win_vld_w)
  );

  assign win_onehot_w = win_vld_w ? (N'(1) << win_idx_w) : '0;
  assign hot_w        = req_valid_i & elig_w & req_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o       <= '0;
      grant_idx_o   <= '0;
      grant_valid_o <= 1'b0;
      armed_q       <= 1'b0;
    end else begin
      grant_o       <= win_onehot_w;
      grant_idx_o   <= win_vld_w ? win_idx_w : '0;
      grant_valid_o <= win_vld_w;
      armed_q       <= 1'b1;
    end
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R6
  grant_idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_o == (N'(1) << grant_idx_o)));

  // R5
  idle_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ($past(req_valid_i) == '0)) |-> (!grant_valid_o && (grant_o == '0)));

  // R7
  busy_grants_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ($past(req_valid_i) != '0)) |-> grant_valid_o);

  // R9
  pick_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && grant_valid_o) |-> ((($past(req_valid_i) >> grant_idx_o) & N'(1)) != '0));

  // R1
  group_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && grant_valid_o && (($past(req_valid_i) & $past(elig_w)) != '0))
      |-> ((($past(elig_w) >> grant_idx_o) & N'(1)) != '0));

  // R2
  hit_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && grant_valid_o && ($past(hot_w) != '0))
      |-> ((($past(hot_w) >> grant_idx_o) & N'(1)) != '0));

  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (grant_valid_o == $past(win_vld_w)));
endmodule

// File: tb/rqarb_top_tb_top.sv
module rqarb_top_tb_top;
  localparam int N    = 8;
  localparam int NCTX = 4;
  localparam int SW   = 6;
  localparam int CW   = 2;
  localparam int IW   = 3;
  localparam int MOD  = 1 << SW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      v_i;
  logic [N*CW-1:0]   c_i;
  logic [N-1:0]      h_i;
  logic [N*SW-1:0]   s_i;
  logic [SW-1:0]     now_i;
  logic [NCTX-1:0]   bl_i;
  logic [N-1:0]      g_o;
  logic [IW-1:0]     gi_o;
  logic              gv_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  // Stimulus state, restated in plain arrays.
  bit v [N];
  int c [N];
  bit h [N];
  int s [N];
  bit bl [NCTX];
  int now;

  always #5 clk = ~clk;

  rqarb_top #(.N(N), .NCTX(NCTX), .SW(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(v_i), .req_ctx_i(c_i), .req_hit_i(h_i), .req_seq_i(s_i),
    .now_seq_i(now_i), .blacklist_i(bl_i),
    .grant_o(g_o), .grant_idx_o(gi_o), .grant_valid_o(gv_o)
  );

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  task automatic push();
    for (int i = 0; i < N; i++) begin
      v_i[i] = v[i];
      h_i[i] = h[i];
      c_i[i*CW +: CW] = CW'(c[i]);
      s_i[i*SW +: SW] = SW'(s[i]);
    end
    for (int k = 0; k < NCTX; k++) bl_i[k] = bl[k];
    now_i = SW'(now);
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin v[i] = 0; c[i] = 0; h[i] = 0; s[i] = 0; end
    for (int k = 0; k < NCTX; k++) bl[k] = 0;
    now = 0;
  endtask

  // Reference: pairwise rule comparison, scanning upward so earlier slots keep ties.
  task automatic ref_pick(output bit ev, output int ei);
    int age_b, age_i;
    bit ok_b, ok_i;
    ev = 0; ei = 0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        if (!ev) begin ev = 1; ei = i; end
        else begin
          ok_b = !bl[c[ei]]; ok_i = !bl[c[i]];
          age_b = (now - s[ei] + MOD) % MOD;
          age_i = (now - s[i] + MOD) % MOD;
          if (ok_i != ok_b) begin if (ok_i) ei = i; end
          else if (h[i] != h[ei]) begin if (h[i]) ei = i; end
          else if (age_i > age_b) ei = i;
        end
      end
    end
  endtask

  task automatic check_out(string tag, bit ev, int ei);
    logic [N-1:0] eg;
    eg = ev ? (N'(1) << ei) : '0;
    n_run++;
    if (gv_o !== ev || g_o !== eg || gi_o !== IW'(ev ? ei : 0)) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b idx=%0d grant=%b, expected valid=%0b idx=%0d grant=%b",
               tag, gv_o, gi_o, g_o, ev, ev ? ei : 0, eg);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic run(string tag);
    bit ev; int ei;
    push();
    ref_pick(ev, ei);
    @(posedge clk);
    @(negedge clk);
    check_out(tag, ev, ei);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit ev; int ei;
    clear_all();
    for (int i = 0; i < N; i++) begin v[i] = 1; h[i] = 1; end
    push();
    repeat (3) @(negedge clk);
    // R8: outputs idle while reset is held, even with valid inputs.
    check_out("R8 reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: empty buffer.
    clear_all();
    run("R5 empty");
    // R9: invalid slots with the best fields are ignored.
    for (int i = 0; i < N; i++) begin h[i] = 1; s[i] = 40; end
    run("R9 all invalid");
    v[6] = 1; h[6] = 0; s[6] = 0; now = 1;
    run("R9 only weak valid slot");

    // R9: each slot alone, all field values.
    for (int i = 0; i < N; i++)
      for (int f = 0; f < 8; f++) begin
        clear_all();
        v[i] = 1; c[i] = f % NCTX; h[i] = f[2]; s[i] = f * 7; bl[f % NCTX] = f[0];
        run("R9 single slot");
      end

    // R1: every penalty vector, contexts spread, mixed hits and ages.
    for (int b = 0; b < 16; b++) begin
      clear_all();
      for (int i = 0; i < N; i++) begin v[i] = 1; c[i] = i % NCTX; h[i] = i[0]; s[i] = i * 5; end
      for (int k = 0; k < NCTX; k++) bl[k] = b[k];
      now = 50;
      run("R1 penalty sweep");
    end
    clear_all();
    v[0] = 1; c[0] = 1; h[0] = 1; s[0] = 0;
    v[5] = 1; c[5] = 2; h[5] = 0; s[5] = 30;
    bl[1] = 1; now = 31;
    run("R1 old hit penalised loses to young miss");

    // R2: every hit pattern in one group, distinct ages.
    for (int p = 0; p < 256; p++) begin
      clear_all();
      for (int i = 0; i < N; i++) begin v[i] = 1; c[i] = 3; h[i] = p[i]; s[i] = (i * 9) % MOD; end
      now = 63;
      run("R2 hit sweep");
    end

    // R3: age ordering with equal groups and hits.
    for (int t = 0; t < 64; t++) begin
      clear_all();
      for (int i = 0; i < N; i++) begin v[i] = 1; h[i] = 1; s[i] = (t + i * 11) % MOD; end
      now = t;
      run("R3 age sweep");
    end

    // R4: full ties over every subset of valid slots.
    for (int m = 1; m < 256; m++) begin
      clear_all();
      for (int i = 0; i < N; i++) begin v[i] = m[i]; h[i] = 1; s[i] = 10; end
      now = 20;
      run("R4 tie subset");
    end

    // R10: stamps straddling the wrap.
    clear_all();
    v[2] = 1; s[2] = 1; v[4] = 1; s[4] = 62; now = 2;
    run("R10 wrap older high stamp");
    v[1] = 1; s[1] = 63; now = 3;
    run("R10 wrap three stamps");

    // R7: outputs hold until the next edge, then follow.
    clear_all();
    v[3] = 1;
    run("R7 first pattern");
    clear_all();
    v[7] = 1;
    push();
    #1;
    check_out("R7 hold before edge", 1, 3);
    run("R7 second pattern");

    // R1 R2 R3 R4: mixed random patterns.
    for (int it = 0; it < 3000; it++) begin
      int dens;
      clear_all();
      dens = rnd() % 4;
      for (int i = 0; i < N; i++) begin
        v[i] = (rnd() % 4) <= dens;
        c[i] = rnd() % NCTX;
        h[i] = rnd() % 2;
        s[i] = (it % 3 == 0) ? (rnd() % 4) : (rnd() % MOD);
      end
      for (int k = 0; k < NCTX; k++) bl[k] = rnd() % 2;
      now = rnd() % MOD;
      run("R1/R2/R3/R4 mixed");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule